// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Aggregator

This block collects message-signalled interrupt writes and turns them into level interrupts. Each write carries one data byte. The low two bits of the byte pick one of four status registers. The next field is the bit index inside that register. The chosen bit is set and stays set until software clears it. Each of the four status registers drives its own interrupt line, so each line can be wired to a different core. To move an interrupt source to another core, change only the two select bits of its message byte.

Software reads a status register through a small combinational read port. It clears bits by writing ones to that register. A build-time switch picks a reduced variant. In that variant only 8 bits per register are usable, and a message whose index falls outside that range is discarded.

Top module: `msi_irq_agg`

## Requirements
- R1: While reset is asserted, and right after it is released, all four status registers read zero and all four interrupt outputs are low.
- R2: A strobed message with select s = byte bits 1:0 and index k = byte bits 6:2 sets bit k of status register s. The bit is visible on the clock after the strobe, and the other three registers do not change.
- R3: Bit 7 of the message byte has no effect: a byte with bit 7 set updates the registers exactly as the same byte with bit 7 clear.
- R4: Messages with the same index and different select values set bits in different registers.
- R5: A message that hits a bit which is already set leaves every register unchanged.
- R6: Interrupt output i is high exactly while status register i is nonzero. It drops on the clock after the write that clears its last set bit.
- R7: A register write to address a clears each bit of register a where the write data holds a one. Bits where the write data holds a zero keep their value.
- R8: If a message sets a bit in the same cycle that a register write clears that same bit, the bit ends up set.
- R9: With the reduced variant enabled, the index is byte bits 4:2 only. A message with byte bit 5 or bit 6 set is dropped, and bits 31:8 of every register read as zero.
- R10: The read data is the status register selected by the read/write address, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message write strobe |
| msg_data | input | 8 | Message data byte |
| reg_wr | input | 1 | Register write (write-one-to-clear) |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Clear mask |
| reg_rdata | output | 32 | Selected status register |
| irq | output | 4 | Level interrupt, one per status register |

## Verification
Two instances are driven with the same stimulus: one in full mode and one in reduced mode. Index values above 7 show the difference between the modes, because they land only in the full instance.

The directed tests cover the following cases:
- A fixed index sent under each of the four select values. This shows whether the select and index fields are swapped or merged.
- A byte with bit 7 set. This shows whether that bit leaks into the decode.
- A set and a clear on the same bit in the same cycle. This shows the priority between them.

A long random mix of messages and clear writes follows. A behavioural model checks it on every clock, which finds wrong register targeting that the directed tests miss.

// File: rtl/msi_irq_agg.sv
module msi_irq_agg #(
  parameter bit REDUCED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_valid,
  input  logic [7:0]  msg_data,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [3:0]  irq
);
  localparam int IDX_W = REDUCED ? 3 : 5;
  localparam int USED = 1 << IDX_W;
  localparam logic [31:0] KEEP = 32'((64'd1 << USED) - 64'd1);

  logic [31:0] status [4];

  wire [1:0]  sel    = msg_data[1:0];
  wire [4:0]  idx    = msg_data[6:2];
  wire        hit    = msg_valid && (32'(idx) < USED);
  wire [31:0] onehot = 32'd1 << idx;

  for (genvar r = 0; r < 4; r++) begin : g_reg
    wire [31:0] clr = (reg_wr && reg_addr == 2'(r)) ? reg_wdata : 32'd0;
    wire [31:0] set = (hit && sel == 2'(r)) ? onehot : 32'd0;
    always_ff @(posedge clk) begin
      if (!rst_n) status[r] <= '0;
      else        status[r] <= ((status[r] & ~clr) | set) & KEEP;
    end
    assign irq[r] = |status[r];
  end

  assign reg_rdata = status[reg_addr];
endmodule

// File: rtl/msi_irq_agg_chk.sv
module msi_irq_agg_chk #(
  parameter bit REDUCED = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_valid,
  input logic [7:0]  msg_data,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [3:0]  irq,
  input logic [31:0] status [4]
);
  wire [1:0] c_sel = msg_data[1:0];
  wire [4:0] c_idx = msg_data[6:2];
  wire       c_ok  = msg_valid && (REDUCED ? (c_idx < 5'd8) : 1'b1);

  // R2, R3, R8: an accepted message leaves its bit set on the next clock
  assert_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_ok |=> status[$past(c_sel)][$past(c_idx)]);

  // R7: a clear with no colliding message leaves no cleared bit standing
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !(c_ok && c_sel == reg_addr) |=>
      (status[$past(reg_addr)] & $past(reg_wdata)) == 32'd0);

  for (genvar r = 0; r < 4; r++) begin : g_chk
    // R5, R2: with no message and no write, the registers hold
    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid && !reg_wr |=> $stable(status[r]));
    // R6: an interrupt falls only after a write to its own register
    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[r]) |-> $past(reg_wr) && $past(reg_addr) == 2'(r));
  end

  if (REDUCED) begin : g_red
    // R9: the upper bits of the read data are always zero
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[31:8] == 24'd0);
  end
endmodule

bind msi_irq_agg msi_irq_agg_chk #(.REDUCED(REDUCED)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq(irq), .status(status)
);

// File: tb/msi_irq_agg_bench.sv
module msi_irq_agg_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [7:0]  msg_data = 8'd0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] rd_f, rd_s;
  logic [3:0]  irq_f, irq_s;

  int total = 0;
  int bad = 0;
  string phase = "R1";
  logic [31:0] mf [4];
  logic [31:0] ms [4];

  always #(PERIOD/2) clk = ~clk;

  msi_irq_agg #(.REDUCED(1'b0)) u_msi_irq_agg (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_f), .irq(irq_f));

  msi_irq_agg #(.REDUCED(1'b1)) u_msi_irq_agg_small (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_s), .irq(irq_s));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: clear, then set (set wins), reduced keeps 8 bits
  always @(posedge clk) begin
    for (int r = 0; r < 4; r++) begin
      if (!rst_n) begin
        mf[r] = 32'd0;
        ms[r] = 32'd0;
      end else begin
        if (reg_wr && int'(reg_addr) == r) begin
          mf[r] = mf[r] & ~reg_wdata;
          ms[r] = ms[r] & ~reg_wdata & 32'hFF;
        end
        if (msg_valid && int'(msg_data[1:0]) == r) begin
          mf[r][msg_data[6:2]] = 1'b1;
          if (msg_data[6:5] == 2'b00) ms[r][msg_data[4:2]] = 1'b1;
        end
      end
    end
  end

  // per-clock comparison against the model (R6 interrupts, R10 read data)
  always @(negedge clk) begin
    for (int r = 0; r < 4; r++) begin
      check(irq_f[r] == (mf[r] != 0), {phase, " R6 irq full"}, 32'(irq_f[r]), 32'(mf[r] != 0));
      check(irq_s[r] == (ms[r] != 0), {phase, " R6 irq reduced"}, 32'(irq_s[r]), 32'(ms[r] != 0));
    end
    check(rd_f == mf[reg_addr], {phase, " R10 rdata full"}, rd_f, mf[reg_addr]);
    check(rd_s == ms[reg_addr], {phase, " R10 rdata reduced"}, rd_s, ms[reg_addr]);
  end

  task automatic send(input logic [7:0] d);
    @(posedge clk); #1;
    msg_valid = 1'b1; msg_data = d; reg_wr = 1'b0;
    @(posedge clk); #1;
    msg_valid = 1'b0;
  endtask

  task automatic clear(input logic [1:0] a, input logic [31:0] m);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = m; msg_valid = 1'b0;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] ef, input logic [31:0] es, input string tag);
    @(posedge clk); #1;
    reg_addr = a; msg_valid = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    check(rd_f == ef, {tag, " full"}, rd_f, ef);
    check(rd_s == es, {tag, " reduced"}, rd_s, es);
  endtask

  initial begin
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 4; a++) expect_reg(2'(a), 32'd0, 32'd0, "R1 reset");

    phase = "R2";
    send(8'h16);
    expect_reg(2'd2, 32'h20, 32'h20, "R2 set reg2 bit5");
    expect_reg(2'd0, 32'h0, 32'h0, "R2 other reg untouched");

    phase = "R4";
    send(8'h14); send(8'h15); send(8'h17);
    expect_reg(2'd0, 32'h20, 32'h20, "R4 reg0");
    expect_reg(2'd1, 32'h20, 32'h20, "R4 reg1");
    expect_reg(2'd3, 32'h20, 32'h20, "R4 reg3");

    phase = "R3";
    send(8'h89);
    expect_reg(2'd1, 32'h24, 32'h24, "R3 bit7 ignored");

    phase = "R5";
    send(8'h16);
    expect_reg(2'd2, 32'h20, 32'h20, "R5 repeat set");

    phase = "R7";
    send(8'h00);
    clear(2'd0, 32'h20);
    expect_reg(2'd0, 32'h1, 32'h1, "R7 partial clear");

    phase = "R6";
    clear(2'd0, 32'h1);
    @(negedge clk);
    check(irq_f[0] == 1'b0 && irq_s[0] == 1'b0, "R6 irq0 drops", 32'({irq_f[0], irq_s[0]}), 32'd0);

    phase = "R9";
    send(8'h53);
    expect_reg(2'd3, 32'h100020, 32'h20, "R9 high index");
    send(8'h1F);
    expect_reg(2'd3, 32'h1000A0, 32'hA0, "R9 index 7");

    phase = "R8";
    @(posedge clk); #1;
    msg_valid = 1'b1; msg_data = 8'h0D;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hFFFFFFFF;
    @(posedge clk); #1;
    msg_valid = 1'b0; reg_wr = 1'b0;
    expect_reg(2'd1, 32'h8, 32'h8, "R8 set wins");

    phase = "R2 random";
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      msg_valid = ($urandom_range(0, 2) != 0);
      msg_data  = 8'($urandom);
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_addr  = 2'($urandom);
      reg_wdata = ($urandom_range(0, 1) != 0) ? $urandom : 32'hFFFFFFFF;
    end
    @(posedge clk); #1;
    msg_valid = 1'b0; reg_wr = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule